// File: doc/BRIEF.md
# First-Order Sigma-Delta Loop with Second-Order Decimator

This block is the digital half of a first-order sigma-delta converter. The resistor-capacitor integrator and the comparator sit outside the chip. On every clock the block takes the comparator decision, passes it through a synchronizer, and registers it. The registered bit goes back out as the one-bit feedback level, which the external network subtracts at the summing node. The same bit feeds a second-order cascaded integrator-comb (sinc2) decimator. Its integrators run at the modulator clock and its combs run at the decimated rate.

Once per `OSR` clocks (2048 by default) the filter produces a result in `ACC_W` bits (26 by default). The block then presents the upper `OUT_W` bits (16 by default) on `out_sample` together with a one-clock `out_valid` strobe. The first outputs after reset come from a partly filled filter window. A small state machine with the states SETTLE_FIRST, SETTLE_SECOND and STEADY marks the first two of them with `out_settling`. The machine moves from SETTLE_FIRST to SETTLE_SECOND on the first decimation tick, from SETTLE_SECOND to STEADY on the second tick, and stays in STEADY until reset.

Top module: `sdm_sinc2_decim`

## Requirements
- R1: `fb_out` shows the `cmp_in` level that was sampled three rising edges earlier. The path is two synchronizer flops and then the decision flop. Until three edges have passed since reset, `fb_out` is 0.
- R2: A registered decision of 1 adds +1 to the filter input and a decision of 0 adds nothing. A constant 0 input therefore gives `out_sample` = 0. A constant 1 input, once the window is full, gives OSR² / 2^(ACC_W−OUT_W), which is 4096 with the default parameters.
- R3: `out_valid` is high for exactly one clock out of every OSR clocks. The first strobe follows the OSR-th rising edge after reset is released.
- R4: On a strobe, `out_sample` equals bits [ACC_W−1 : ACC_W−OUT_W] of the sum over lags j = 1 … 2·OSR−1 of w(j)·d. Here w(j) = j for j ≤ OSR and w(j) = 2·OSR − j otherwise, and d is the decision that reached the filter j+1 edges before the strobe edge.
- R5: Between strobes, `out_sample` holds the last presented value. It is 0 before the first strobe.
- R6: `out_settling` is high together with the first and second `out_valid` strobes after reset and low with every later strobe. It is never high without `out_valid`.
- R7: While reset is asserted, `fb_out`, `out_valid`, `out_settling` and `out_sample` are all 0.
- R8: The integrators wrap in two's complement. Outputs stay correct after a long run of ones has carried the second integrator past 2^ACC_W.
- R9: A reset in the middle of a run restarts the output period and the settling sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Comparator decision, asynchronous (1 when the integrator node is at or above the reference) |
| fb_out | output | 1 | Registered decision driven to the one-bit feedback DAC |
| out_sample | output | OUT_W | Upper bits of the sinc2 result |
| out_valid | output | 1 | One-clock strobe marking a new sample |
| out_settling | output | 1 | Marks the first two samples after reset |

## Verification
A `cmp_in` level driven before rising edge e appears on `fb_out` just after edge e+2. A decision first affects the filter at edge e+3. A filter result is registered on the edge where the decimation count reaches OSR−1, which is edge OSR−1 counted from zero after reset release, and it is visible from that edge until the next one. The bench drives `cmp_in` at falling edges and samples every output at the next falling edge. Its model keeps a queue of the levels it drove. From that queue it takes the expected feedback bit two entries back and forms the triangular weighted sum over the decisions delayed by three edges. It compares the strobe, the flag and the sample on every clock.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE_FIRST  = 2'd0,
        ST_SETTLE_SECOND = 2'd1,
        ST_STEADY        = 2'd2
    } settle_state_e;
endpackage

// File: rtl/sdm_fb_sync.sv
module sdm_fb_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_async,
    output logic bit_q
);
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            bit_q  <= 1'b0;
        end else begin
            sync_q[0] <= cmp_async;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            bit_q <= sync_q[SYNC_STAGES-1];
        end
    end
endmodule

// File: rtl/sdm_cic_integ.sv
module sdm_cic_integ #(
    parameter int ORDER = 2,
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [ACC_W-1:0] integ_out
);
    logic [ORDER-1:0][ACC_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc[0] <= acc[0] + ACC_W'(bit_in);
            for (int i = 1; i < ORDER; i++) begin
                acc[i] <= acc[i] + acc[i-1];
            end
        end
    end

    assign integ_out = acc[ORDER-1];
endmodule

// File: rtl/sdm_cic_comb.sv
module sdm_cic_comb #(
    parameter int ORDER = 2,
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [ACC_W-1:0] integ_in,
    output logic [ACC_W-1:0] res_out
);
    logic [ORDER-1:0][ACC_W-1:0] dly;
    logic [ORDER:0][ACC_W-1:0]   stage;

    always_comb begin
        stage[0] = integ_in;
        for (int i = 0; i < ORDER; i++) begin
            stage[i+1] = stage[i] - dly[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly     <= '0;
            res_out <= '0;
        end else if (tick) begin
            for (int i = 0; i < ORDER; i++) begin
                dly[i] <= stage[i];
            end
            res_out <= stage[ORDER];
        end
    end
endmodule

// File: rtl/sdm_decim_ctrl.sv
module sdm_decim_ctrl
    import sdm_pkg::*;
#(
    parameter int OSR = 2048
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic valid_q,
    output logic settle_q
);
    localparam int CNT_W = $clog2(OSR);

    logic [CNT_W-1:0] cnt;
    settle_state_e    state_q, state_d;

    assign tick = (cnt == CNT_W'(OSR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= tick ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SETTLE_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE_FIRST:  if (tick) state_d = ST_SETTLE_SECOND;
            ST_SETTLE_SECOND: if (tick) state_d = ST_STEADY;
            ST_STEADY:        state_d = ST_STEADY;
            default:          state_d = ST_SETTLE_FIRST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            settle_q <= 1'b0;
        end else begin
            valid_q  <= tick;
            settle_q <= tick && (state_q != ST_STEADY);
        end
    end
endmodule

// File: rtl/sdm_sinc2_decim.sv
module sdm_sinc2_decim #(
    parameter int OSR         = 2048,
    parameter int ACC_W       = 26,
    parameter int OUT_W       = 16,
    parameter int ORDER       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    output logic             fb_out,
    output logic [OUT_W-1:0] out_sample,
    output logic             out_valid,
    output logic             out_settling
);
    localparam int SHIFT = ACC_W - OUT_W;

    logic             bit_q;
    logic             tick;
    logic [ACC_W-1:0] integ_w;
    logic [ACC_W-1:0] res_w;
    logic             unused_lsbs;

    sdm_fb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cmp_async(cmp_in), .bit_q(bit_q)
    );

    sdm_cic_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_q), .integ_out(integ_w)
    );

    sdm_decim_ctrl #(.OSR(OSR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .valid_q(out_valid), .settle_q(out_settling)
    );

    sdm_cic_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .integ_in(integ_w), .res_out(res_w)
    );

    assign fb_out      = bit_q;
    assign out_sample  = res_w[ACC_W-1 -: OUT_W];
    assign unused_lsbs = ^res_w[SHIFT-1:0];
endmodule

// File: rtl/sdm_sinc2_decim_chk.sv
module sdm_sinc2_decim_chk #(
    parameter int OSR   = 2048,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_in,
    input logic             fb_out,
    input logic [OUT_W-1:0] out_sample,
    input logic             out_valid,
    input logic             out_settling
);
    int         gap_cnt;
    logic [1:0] since_rst;
    logic [1:0] strobes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt   <= 0;
            since_rst <= '0;
            strobes   <= '0;
        end else begin
            gap_cnt <= out_valid ? 1 : gap_cnt + 1;
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            if (out_valid && strobes != 2'd2) strobes <= strobes + 2'd1;
        end
    end

    // R1: feedback bit trails the comparator by three edges
    p_fb_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (fb_out == $past(cmp_in, 3)));

    // R3: strobes are OSR clocks apart, first one OSR edges after reset
    p_valid_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (gap_cnt == OSR));

    // R3: strobe lasts one clock
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5: sample held between strobes
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));

    // R6: flag only with a strobe
    p_settle_only_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_settling |-> out_valid);

    // R6: first two strobes flagged
    p_settle_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && strobes != 2'd2) |-> out_settling);

    // R6: later strobes not flagged
    p_settle_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && strobes == 2'd2) |-> !out_settling);
endmodule

bind sdm_sinc2_decim sdm_sinc2_decim_chk #(.OSR(OSR), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .fb_out(fb_out),
    .out_sample(out_sample), .out_valid(out_valid), .out_settling(out_settling)
);

// File: tb/sdm_sinc2_decim_test.sv
`timescale 1ns/1ps
module sdm_sinc2_decim_test;
    localparam int OSR   = 2048;
    localparam int ACC_W = 26;
    localparam int OUT_W = 16;
    localparam int SHIFT = ACC_W - OUT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp_in = 1'b0;
    logic             fb_out, out_valid, out_settling;
    logic [OUT_W-1:0] out_sample;

    sdm_sinc2_decim #(.OSR(OSR), .ACC_W(ACC_W), .OUT_W(OUT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .fb_out(fb_out),
        .out_sample(out_sample), .out_valid(out_valid), .out_settling(out_settling)
    );

    always #2.5 clk = ~clk;

    int               n_vec = 0;
    int               n_bad = 0;
    bit               done = 1'b0;
    bit               hist[$];
    int               e_cur = 0;
    int               n_out = 0;
    logic [OUT_W-1:0] last_sample = '0;
    logic [15:0]      lfsr = 16'hACE1;
    string            seg_req = "R4";

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cmp_at(int m);
        int idx;
        if (m < 0) return 0;
        idx = hist.size() - 1 - (e_cur - m);
        if (idx < 0) return 0;
        return int'(hist[idx]);
    endfunction

    function automatic longint ref_sum();
        longint s = 0;
        for (int j = 1; j < 2 * OSR; j++) begin
            int w = (j <= OSR) ? j : 2 * OSR - j;
            s += longint'(w) * cmp_at(e_cur - 4 - j);
        end
        return s;
    endfunction

    task automatic check_edge();
        logic [63:0] exp_s;
        chk("R1", "fb_out", fb_out, cmp_at(e_cur - 2));
        if (((e_cur + 1) % OSR) == 0) begin
            exp_s = ref_sum() >> SHIFT;
            chk("R3", "out_valid", out_valid, 1);
            chk(seg_req, "out_sample", out_sample, exp_s[OUT_W-1:0]);
            chk("R6", "out_settling", out_settling, (n_out < 2) ? 1 : 0);
            n_out++;
            last_sample = exp_s[OUT_W-1:0];
        end else begin
            chk("R3", "out_valid", out_valid, 0);
            chk("R6", "out_settling", out_settling, 0);
            chk("R5", "out_sample hold", out_sample, last_sample);
        end
    endtask

    task automatic step(input bit v);
        cmp_in = v;
        hist.push_back(v);
        if (hist.size() > 2 * OSR + 8) void'(hist.pop_front());
        @(posedge clk);
        @(negedge clk);
        check_edge();
        e_cur++;
    endtask

    function automatic bit pat(int kind);
        case (kind)
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return (e_cur % 4) == 0;
            3:       return e_cur[0];
            default: return lfsr[0];
        endcase
    endfunction

    task automatic run_seg(input int kind, input int nsteps, input string req);
        seg_req = req;
        for (int i = 0; i < nsteps; i++) begin
            step(pat(kind));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst_n  = 1'b0;
        cmp_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(req, "fb_out in reset", fb_out, 0);
        chk(req, "out_valid in reset", out_valid, 0);
        chk(req, "out_settling in reset", out_settling, 0);
        chk(req, "out_sample in reset", out_sample, 0);
        rst_n = 1'b1;
        hist.delete();
        e_cur = 0;
        n_out = 0;
        last_sample = '0;
    endtask

    initial begin
        do_reset("R7");
        run_seg(0, 2 * OSR, "R2");     // constant zero
        run_seg(1, 7 * OSR, "R8");     // long run of ones, integrator wraps
        run_seg(2, 2 * OSR, "R4");     // density one quarter
        run_seg(3, 2 * OSR, "R4");     // alternating
        run_seg(4, 3 * OSR, "R4");     // pseudo-random
        run_seg(1, 700, "R4");         // partial period before reset
        do_reset("R9");
        run_seg(1, 3 * OSR, "R9");     // settling restarts after reset
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule